// File: doc/BRIEF.md
# System Reset Pulse Generator

This block drives the backplane-wide reset request. It merges three reset sources into one active-high output: a local reset pin, a power-up reset pin (both active low) and a software reset bit from a control register. Every assertion of the output is stretched to a guaranteed minimum length, however short the event that caused it. An external inverting open-collector stage turns the output into the active-low backplane reset line.

The two pins are asynchronous and pass through a synchronizer before use. The power-up pin also forces the output high at once, with no clock needed. The software bit is a level from the same clock domain. It is sampled directly. An acknowledge flag lets software see that its request took effect, so that it can clear the bit.

The minimum length is the parameter `PULSE_CYCLES`, in clock cycles. Its default is the clock frequency times 200 ms, which gives 3,200,000 cycles at 16 MHz. The count restarts on every clock edge at which any source is active. So the output lasts for the full count after the last source goes inactive.

Top module: `sysrst_gen`

## Requirements
- R1: The output `sys_rst_o` asserts when `loc_rst_ni` is low. The pin passes through two synchronizer flops, so the output is high after the third rising edge that samples the pin low. A low level seen by a single edge is enough.
- R2: While `sw_rst_i` is 1 at a rising edge, `sys_rst_o` is 1 after that edge.
- R3: While `pwrup_rst_ni` is low, `sys_rst_o` is 1 and `sw_ack_o` is 0. This holds asynchronously, with no clock edge needed.
- R4: Let E be the last edge at which an active source was seen (software bit at E, or a synchronized pin request). The output stays 1 for exactly `PULSE_CYCLES` edges after E. It falls at edge E+`PULSE_CYCLES`, even for a single-cycle trigger.
- R5: A source that becomes active while the output is stretched restarts the full count. This includes a source first seen at the edge where the output would otherwise fall.
- R6: `sw_ack_o` is 1 after an edge at which `sw_rst_i` and `sys_rst_o` were both 1. It is 0 after an edge at which `sw_rst_i` was 0.
- R7: While `rst_ni` is low, `sys_rst_o` is 1 and `sw_ack_o` is 0. After `rst_ni` is released, a full `PULSE_CYCLES` pulse follows. The pin synchronizers restart in the active state.
- R8: Once the count has elapsed with all sources inactive, `sys_rst_o` is 0. It stays 0 while no source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| loc_rst_ni | input | 1 | Local reset pin, active low, asynchronous |
| pwrup_rst_ni | input | 1 | Power-up reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset request bit, level |
| sys_rst_o | output | 1 | Stretched reset drive, active high |
| sw_ack_o | output | 1 | Software request observed flag |

## Verification
Two functions can fall in the same cycle. The first is the expiry of the stretch count. The second is a new request that restarts it. The bench pulses the software bit once, then raises it again so that it is sampled at exactly the edge where the output would drop. The output must then stay high and the count must start again. A behavioural model compares every cycle, and a direct check looks at that edge. A second collision comes from driving the local pin and the software bit together, and then releasing them together. The fall edge is then judged against the later of the two request paths: the synchronized pin.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  typedef enum int unsigned {
    PIN_LOC = 0,
    PIN_PWR = 1
  } pin_idx_e;

  localparam int unsigned NUM_PINS = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
  parameter int unsigned PULSE_CYCLES = 3200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o
);
  localparam int unsigned CNT_W = sysrst_pkg::cnt_width(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  // reload on any request; drop when the last remaining cycle is consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_LOAD;
      act_q <= 1'b1;
    end else if (req_i) begin
      cnt_q <= CNT_LOAD;
      act_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
      act_q <= (cnt_q > CNT_ONE);
    end else begin
      act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen #(
  parameter int unsigned CLK_HZ       = 16000000,
  parameter int unsigned MIN_MS       = 200,
  parameter int unsigned PULSE_CYCLES = CLK_HZ / 1000 * MIN_MS,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loc_rst_ni,
  input  logic pwrup_rst_ni,
  input  logic sw_rst_i,
  output logic sys_rst_o,
  output logic sw_ack_o
);
  import sysrst_pkg::*;

  logic                arst_n;
  logic [NUM_PINS-1:0] pin_req;
  logic [NUM_PINS-1:0] pin_req_s;
  logic                any_req;
  logic                ack_q;

  // power-up pin forces the whole block into its asserted state
  assign arst_n = rst_ni & pwrup_rst_ni;

  assign pin_req[PIN_LOC] = ~loc_rst_ni;
  assign pin_req[PIN_PWR] = ~pwrup_rst_ni;

  sysrst_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(arst_n),
    .d_i   (pin_req),
    .q_o   (pin_req_s)
  );

  assign any_req = (|pin_req_s) | sw_rst_i;

  sysrst_stretch #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (arst_n),
    .req_i   (any_req),
    .active_o(sys_rst_o)
  );

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) ack_q <= 1'b0;
    else         ack_q <= sw_rst_i & sys_rst_o;
  end

  assign sw_ack_o = ack_q;
endmodule

// File: rtl/sysrst_gen_chk.sv
module sysrst_gen_chk #(
  parameter int unsigned PULSE_CYCLES = 3200000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic loc_rst_ni,
  input logic pwrup_rst_ni,
  input logic sw_rst_i,
  input logic sys_rst_o,
  input logic sw_ack_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!sys_rst_o)      run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + 32'd1;
  end

  a_r1_loc_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loc_rst_ni && $past(!loc_rst_ni) && $past(!loc_rst_ni, 2)) |=> sys_rst_o);

  a_r2_sw_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> sys_rst_o);

  a_r3_pwrup_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrup_rst_ni |-> (sys_rst_o && !sw_ack_o));

  a_r4_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (run_q >= PULSE_CYCLES));

  a_r4_no_fall_on_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(!sw_rst_i));

  a_r6_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_ack_o) |-> ($past(sw_rst_i) && $past(sys_rst_o)));

  a_r6_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_rst_i |=> !sw_ack_o);
endmodule

bind sysrst_gen sysrst_gen_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .loc_rst_ni  (loc_rst_ni),
  .pwrup_rst_ni(pwrup_rst_ni),
  .sw_rst_i    (sw_rst_i),
  .sys_rst_o   (sys_rst_o),
  .sw_ack_o    (sw_ack_o)
);

// File: tb/sysrst_gen_bench.sv
`timescale 1ns/1ps
module sysrst_gen_bench;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic loc_n = 1'b1;
  logic pwr_n = 1'b1;
  logic sw = 1'b0;
  logic out;
  logic ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysrst_gen #(.PULSE_CYCLES(N)) u_sysrst_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .loc_rst_ni  (loc_n),
    .pwrup_rst_ni(pwr_n),
    .sw_rst_i    (sw),
    .sys_rst_o   (out),
    .sw_ack_o    (ack)
  );

  // behavioural model: pin history delayed two edges, cycle of last request
  bit dq[$] = '{1'b1, 1'b1};
  int cyc = 0;
  int last = 0;
  bit m_out = 1'b1;
  bit m_ack = 1'b0;

  always @(posedge clk or negedge rst_n or negedge pwr_n) begin
    if (!rst_n || !pwr_n) begin
      dq = '{1'b1, 1'b1};
      last = cyc;
      m_out = 1'b1;
      m_ack = 1'b0;
    end else begin
      bit d;
      cyc++;
      d = dq.pop_front();
      dq.push_back(!loc_n);
      m_ack = sw && m_out;
      if (d || sw) last = cyc;
      m_out = (cyc - last) < N;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out, m_out, "R4 model sys_rst_o");
      chk(ack, m_ack, "R6 model sw_ack_o");
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    wait_neg(3);
    chk(out, 1'b1, "R7 reset out");
    chk(ack, 1'b0, "R7 reset ack");
    rst_n = 1'b1;
    wait_neg(1);
    chk(out, 1'b1, "R7 pulse after reset");
    wait_neg(N + 2);
    chk(out, 1'b0, "R8 idle after reset pulse");
    wait_neg(5);
    chk(out, 1'b0, "R8 stays idle");

    // single-cycle sw pulse, then retrigger exactly at expiry edge
    sw = 1'b1;
    wait_neg(1);
    sw = 1'b0;
    chk(out, 1'b1, "R2 sw asserts");
    wait_neg(N - 1);
    chk(out, 1'b1, "R4 still high before expiry");
    sw = 1'b1;
    wait_neg(1);
    sw = 1'b0;
    chk(out, 1'b1, "R5 retrigger at expiry");
    wait_neg(N - 1);
    chk(out, 1'b1, "R5 full count after retrigger");
    wait_neg(1);
    chk(out, 1'b0, "R4 exact fall");
    wait_neg(3);

    // local pin low seen by one edge
    loc_n = 1'b0;
    wait_neg(1);
    loc_n = 1'b1;
    wait_neg(1);
    chk(out, 1'b0, "R1 sync latency");
    wait_neg(1);
    chk(out, 1'b1, "R1 local asserts");
    wait_neg(N + 4);
    chk(out, 1'b0, "R8 after local");

    // long local hold
    loc_n = 1'b0;
    wait_neg(30);
    chk(out, 1'b1, "R1 held");
    loc_n = 1'b1;
    wait_neg(N + 4);

    // ack handshake
    sw = 1'b1;
    wait_neg(3);
    chk(ack, 1'b1, "R6 ack set");
    sw = 1'b0;
    wait_neg(1);
    chk(ack, 1'b0, "R6 ack cleared");
    chk(out, 1'b1, "R4 out held after sw drop");
    wait_neg(N + 4);

    // power-up pin, asynchronous
    #2 pwr_n = 1'b0;
    #1 chk(out, 1'b1, "R3 async assert");
    chk(ack, 1'b0, "R3 ack low");
    wait_neg(3);
    pwr_n = 1'b1;
    wait_neg(N + 4);
    chk(out, 1'b0, "R8 after pwrup");

    // local and sw together, released together
    loc_n = 1'b0;
    sw = 1'b1;
    wait_neg(5);
    loc_n = 1'b1;
    sw = 1'b0;
    wait_neg(N + 1);
    chk(out, 1'b1, "R4 combined held by sync path");
    wait_neg(2);
    chk(out, 1'b0, "R8 combined released");
    wait_neg(3);
    finish_run();
  end
endmodule